// File: doc/BRIEF.md
# Multichannel SPI ADC Scan Sequencer

This block is the hardware master for a multichannel successive-approximation ADC that sits on an SPI link. The converter takes single-byte commands and returns each result as a big-endian 16-bit word. After reset the block sends a fixed setup sequence on its own. From then on, each start request takes a channel-enable mask, a temperature flag and a single/scan selector. The block builds the conversion command, waits for the conversion to finish, reads the result words back and emits them as a stream of 16-bit samples. Each sample is tagged with its channel number or marked as a temperature sample.

The converter cannot return an arbitrary subset of channels. A scan therefore always converts from channel 0 up to the highest enabled channel. When requested, the temperature word is placed ahead of the voltage words. The end of a conversion is detected in one of two ways, chosen by a parameter. The first is a falling edge on the converter's end-of-conversion line, guarded by a timeout. The second is a fixed wait per converted channel. The SPI byte engine runs in mode 0, and its clock is the system clock divided by a fixed divider.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the block sends three single-byte frames, in this order: 0x10 (converter reset), 0x20 (averaging off), 0x68 (setup: reference mode 2 in bits 3:2, start-on-command clocking 10 in bits 5:4). busy_o stays high until this sequence ends.
- R2: SPI runs in mode 0. sclk_o is low whenever cs_no is high. Data goes out MSB first, and miso_i is sampled on the rising edge. sclk_o is high for exactly CLK_DIV system cycles and low for CLK_DIV cycles.
- R3: A scan command byte is 0x80 | N<<3 | T. N is the highest set bit of ch_mask_i and sits in bits 6:3. T is temp_i and sits in bit 0. The scan-mode bits 2:1 are 00. An all-zero mask gives N = 0.
- R4: A single read uses scan-mode bits 2:1 = 11. For a voltage read the command is 0x86 | N<<3. For a temperature read it is 0x87, and the mask is ignored.
- R5: cs_no goes high for at least 2*CLK_DIV cycles between the command frame and the readback frame. It then stays low for the whole readback, including any time the output stream is stalled.
- R6: A scan emits N+1+T samples. The temperature sample comes first (smp_temp_o = 1, smp_ch_o = 0), then channels 0 to N in ascending order. smp_last_o is set only on the final sample.
- R7: The readback length is 2 bytes per scanned word. A single temperature read clocks 4 bytes, emits only the first word, and marks that word last. A single voltage read clocks 2 bytes and emits one sample, marked last.
- R8: When EOC_IRQ = 1, the readback starts only after a falling edge on eoc_ni. If no edge arrives within TIMEOUT_CYC cycles, err_o is set and stays set, no sample is emitted, and the block returns to idle. The next accepted start clears err_o.
- R9: When EOC_IRQ = 0, the readback starts no earlier than CONV_CYC times the number of converted words, counted in cycles from the end of the command frame.
- R10: When RES_BITS = 10, smp_data_o is the received word shifted right by 2. When RES_BITS = 12, it is the word unchanged.
- R11: While smp_valid_o is high and smp_ready_i is low, smp_valid_o, smp_data_o, smp_ch_o, smp_temp_o and smp_last_o hold their values.
- R12: start_i is ignored while busy_o is high. Such a request sends no command byte and produces no samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| single_i | input | 1 | 1: single read, 0: scan |
| temp_i | input | 1 | Include temperature (scan) or read temperature (single) |
| ch_mask_i | input | NUM_CH | Channel-enable mask |
| busy_o | output | 1 | Setup or request in progress |
| err_o | output | 1 | Sticky end-of-conversion timeout flag |
| smp_valid_o | output | 1 | Sample valid |
| smp_ready_i | input | 1 | Sample accepted |
| smp_data_o | output | 16 | Sample value |
| smp_ch_o | output | $clog2(NUM_CH) | Channel tag |
| smp_temp_o | output | 1 | Sample is the temperature word |
| smp_last_o | output | 1 | Final sample of the request |
| cs_no | output | 1 | SPI chip select, active low |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to converter |
| miso_i | input | 1 | SPI data from converter |
| eoc_ni | input | 1 | End-of-conversion line, falling edge active |

## Verification
The final sample handshake of a readback and a new start request can land in the same clock cycle. The bench provokes this by holding start_i high from just after a start is accepted until busy_o falls, with a stalling ready pattern that moves the last handshake around. The collision is judged at the pins. The converter model must log exactly one new command byte for that request. The monitor must see no sample beyond those queued. A timeout run, in which the converter model suppresses the end-of-conversion edge, checks that the error path emits nothing and that the next start clears err_o.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_BOOT, ST_CMD, ST_GAP, ST_IDLE, ST_WAIT, ST_RD, ST_OUT
  } seq_state_e;

  typedef enum logic [1:0] {PH_INIT, PH_CONV, PH_DONE} seq_phase_e;

  localparam logic [1:0] INIT_LAST = 2'd2;

  // boot sequence: reset, averaging off, setup (ref mode 2, start on command)
  function automatic logic [7:0] init_cmd(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h10;
      2'd1:    return 8'h20;
      default: return 8'h68;
    endcase
  endfunction
endpackage

// File: rtl/adc_spi_byte.sv
module adc_spi_byte #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int DIVW = $clog2(CLK_DIV) + 1;

  logic [7:0]      tx_q, rx_q;
  logic [2:0]      bit_q;
  logic [DIVW-1:0] div_q;
  logic            act_q, sclk_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0; rx_q <= '0; bit_q <= '0; div_q <= '0;
      act_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start_i) begin
          act_q <= 1'b1; tx_q <= tx_i; bit_q <= '0; div_q <= '0; sclk_q <= 1'b0;
        end
      end else if (div_q == DIVW'(CLK_DIV - 1)) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          tx_q   <= {tx_q[6:0], 1'b0};
          if (bit_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
          end
        end
      end else begin
        div_q <= div_q + DIVW'(1);
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];
endmodule

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eoc_ni,
  output logic fall_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 3'b111;
    else         sync_q <= {sync_q[1:0], eoc_ni};
  end

  assign fall_o = sync_q[2] & ~sync_q[1];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int RES_BITS    = 12,
  parameter bit EOC_IRQ     = 1'b1,
  parameter int CONV_CYC    = 200,
  parameter int TIMEOUT_CYC = 50_000_000,
  parameter int GAP_CYC     = 8,
  localparam int CHW        = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              single_i,
  input  logic              temp_i,
  input  logic [NUM_CH-1:0] ch_mask_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              smp_valid_o,
  input  logic              smp_ready_i,
  output logic [15:0]       smp_data_o,
  output logic [CHW-1:0]    smp_ch_o,
  output logic              smp_temp_o,
  output logic              smp_last_o,
  output logic              cs_no,
  output logic              spi_start_o,
  output logic [7:0]        spi_tx_o,
  input  logic              spi_done_i,
  input  logic [7:0]        spi_rx_i,
  input  logic              eoc_fall_i
);
  localparam int WW    = CHW + 2;
  localparam int SHIFT = (RES_BITS == 10) ? 2 : 0;

  seq_state_e state_q;
  seq_phase_e phase_q;
  logic [1:0]     init_q;
  logic [31:0]    cnt_q, tgt_q;
  logic [WW-1:0]  words_q;
  logic [CHW-1:0] tag_ch_q;
  logic           tag_temp_q, single_q, temp_q, hi_q, valid_q, cs_q, err_q, start_q;
  logic [7:0]     tx_q;
  logic [15:0]    word_q;

  logic [CHW-1:0] hi_ch;
  logic [WW-1:0]  n_words, n_conv;
  logic [7:0]     conv_cmd;

  always_comb begin
    hi_ch = '0;
    for (int i = 0; i < NUM_CH; i++) if (ch_mask_i[i]) hi_ch = CHW'(i);
  end

  always_comb begin
    n_conv   = single_i ? WW'(1) : WW'(hi_ch) + WW'(1) + WW'(temp_i);
    n_words  = (single_i && temp_i) ? WW'(2) : n_conv;
    conv_cmd = {1'b1, (single_i && temp_i) ? 4'd0 : 4'(hi_ch),
                single_i ? 2'b11 : 2'b00, temp_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT; phase_q <= PH_INIT; init_q <= '0;
      cnt_q <= '0; tgt_q <= '0; words_q <= '0; tag_ch_q <= '0;
      tag_temp_q <= 1'b0; single_q <= 1'b0; temp_q <= 1'b0; hi_q <= 1'b0;
      valid_q <= 1'b0; cs_q <= 1'b1; err_q <= 1'b0; start_q <= 1'b0;
      tx_q <= '0; word_q <= '0;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        ST_BOOT: begin
          cs_q <= 1'b0; tx_q <= init_cmd(init_q); start_q <= 1'b1; state_q <= ST_CMD;
        end
        ST_CMD: if (spi_done_i) begin
          cs_q <= 1'b1; cnt_q <= '0; state_q <= ST_GAP;
        end
        ST_GAP: begin
          cnt_q <= cnt_q + 32'd1;
          if (cnt_q == 32'(GAP_CYC - 1)) begin
            cnt_q <= '0;
            case (phase_q)
              PH_INIT: if (init_q == INIT_LAST) state_q <= ST_IDLE;
                       else begin init_q <= init_q + 2'd1; state_q <= ST_BOOT; end
              PH_CONV: state_q <= ST_WAIT;
              default: state_q <= ST_IDLE;
            endcase
          end
        end
        ST_IDLE: if (start_i) begin
          single_q <= single_i; temp_q <= temp_i; words_q <= n_words;
          tag_temp_q <= temp_i;
          tag_ch_q <= (single_i && !temp_i) ? hi_ch : '0;
          tgt_q <= 32'(CONV_CYC) * 32'(n_conv);
          err_q <= 1'b0; cs_q <= 1'b0; tx_q <= conv_cmd; start_q <= 1'b1;
          phase_q <= PH_CONV; state_q <= ST_CMD;
        end
        ST_WAIT: begin
          cnt_q <= cnt_q + 32'd1;
          if (EOC_IRQ ? eoc_fall_i : (cnt_q + 32'd1 >= tgt_q)) begin
            cs_q <= 1'b0; tx_q <= '0; start_q <= 1'b1; hi_q <= 1'b1; state_q <= ST_RD;
          end else if (EOC_IRQ && cnt_q == 32'(TIMEOUT_CYC - 1)) begin
            err_q <= 1'b1; state_q <= ST_IDLE;
          end
        end
        ST_RD: if (spi_done_i) begin
          if (hi_q) begin
            word_q[15:8] <= spi_rx_i; hi_q <= 1'b0; start_q <= 1'b1;
          end else begin
            word_q[7:0] <= spi_rx_i;
            if (single_q && temp_q && words_q == WW'(1)) begin
              cs_q <= 1'b1; cnt_q <= '0; phase_q <= PH_DONE; state_q <= ST_GAP;
            end else begin
              valid_q <= 1'b1; state_q <= ST_OUT;
            end
          end
        end
        ST_OUT: if (smp_ready_i) begin
          valid_q <= 1'b0;
          if (words_q == WW'(1)) begin
            cs_q <= 1'b1; cnt_q <= '0; phase_q <= PH_DONE; state_q <= ST_GAP;
          end else begin
            words_q <= words_q - WW'(1);
            if (tag_temp_q) tag_temp_q <= 1'b0;
            else            tag_ch_q   <= tag_ch_q + CHW'(1);
            start_q <= 1'b1; hi_q <= 1'b1; state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign err_o       = err_q;
  assign smp_valid_o = valid_q;
  assign smp_data_o  = word_q >> SHIFT;
  assign smp_ch_o    = tag_ch_q;
  assign smp_temp_o  = tag_temp_q;
  assign smp_last_o  = valid_q && (single_q || words_q == WW'(1));
  assign cs_no       = cs_q;
  assign spi_start_o = start_q;
  assign spi_tx_o    = tx_q;

  // R11
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o && !smp_ready_i |=> smp_valid_o && $stable(smp_data_o) &&
      $stable(smp_ch_o) && $stable(smp_temp_o) && $stable(smp_last_o));
  // R5
  cs_low_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> !cs_no);
  // R12
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  // R8
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o && !smp_valid_o);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NUM_CH      = 8,
  parameter int RES_BITS    = 12,
  parameter bit EOC_IRQ     = 1'b1,
  parameter int CLK_DIV     = 4,
  parameter int CONV_CYC    = 200,
  parameter int TIMEOUT_CYC = 50_000_000,
  localparam int CHW        = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              single_i,
  input  logic              temp_i,
  input  logic [NUM_CH-1:0] ch_mask_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              smp_valid_o,
  input  logic              smp_ready_i,
  output logic [15:0]       smp_data_o,
  output logic [CHW-1:0]    smp_ch_o,
  output logic              smp_temp_o,
  output logic              smp_last_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              eoc_ni
);
  localparam int GAP_CYC = 2 * CLK_DIV;

  logic       spi_start, spi_done, eoc_fall;
  logic [7:0] spi_tx, spi_rx;

  generate
    if (EOC_IRQ) begin : g_irq
      adc_eoc_sync u_eoc (.clk_i, .rst_ni, .eoc_ni, .fall_o(eoc_fall));
    end else begin : g_delay
      assign eoc_fall = 1'b0;
    end
  endgenerate

  adc_spi_byte #(.CLK_DIV(CLK_DIV)) u_spi (
    .clk_i, .rst_ni, .start_i(spi_start), .tx_i(spi_tx), .done_o(spi_done),
    .rx_o(spi_rx), .sclk_o, .mosi_o, .miso_i
  );

  adc_seq_ctrl #(
    .NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .EOC_IRQ(EOC_IRQ),
    .CONV_CYC(CONV_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .single_i, .temp_i, .ch_mask_i, .busy_o, .err_o,
    .smp_valid_o, .smp_ready_i, .smp_data_o, .smp_ch_o, .smp_temp_o, .smp_last_o,
    .cs_no, .spi_start_o(spi_start), .spi_tx_o(spi_tx), .spi_done_i(spi_done),
    .spi_rx_i(spi_rx), .eoc_fall_i(eoc_fall)
  );

  // R2
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_model #(
  parameter int EOC_DLY = 30
) (
  input  logic        clk,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        mosi,
  input  logic        mute,
  output logic        miso,
  output logic        eoc_n,
  output logic [7:0]  last_cmd,
  output int          n_cmds,
  output logic [23:0] first3,
  output int          rd_bytes,
  output int          gap_c,
  output int          wait_c
);
  int cyc = 0, bits = 0, bidx = 0, nwords = 0, rise_c = 0, cmd_end_c = 0;
  bit rd_frame = 0, pending = 0, conv_frame = 0;
  logic [7:0]  sh_in = 0;
  logic [15:0] words [0:17];

  function automatic logic [15:0] raw_val(input int k);
    return 16'h0A00 + 16'(k) * 16'h0013;
  endfunction

  function automatic logic get_bit(input int i);
    if (i / 16 < nwords) return words[i / 16][15 - (i % 16)];
    return 1'b0;
  endfunction

  initial begin
    eoc_n = 1'b1; miso = 1'b0; last_cmd = '0; n_cmds = 0; first3 = '0;
    rd_bytes = 0; gap_c = 0; wait_c = 0;
  end

  always @(posedge clk) cyc++;

  task automatic decode(input logic [7:0] c);
    int n;
    last_cmd = c;
    if (n_cmds < 3) first3 = {first3[15:0], c};
    n_cmds++;
    if (c[7]) begin
      n = int'(c[6:3]);
      nwords = 0;
      conv_frame = 1;
      if (c[2:1] == 2'b11) begin
        if (c[0]) begin
          words[0] = 16'h0C35; words[1] = 16'h0FFF; nwords = 2;
        end else begin
          words[0] = raw_val(n); nwords = 1;
        end
      end else begin
        if (c[0]) begin words[0] = 16'h0C35; nwords = 1; end
        for (int k = 0; k <= n; k++) begin words[nwords] = raw_val(k); nwords++; end
      end
      if (!mute) begin
        pending = 1;
        fork
          begin
            repeat (EOC_DLY) @(posedge clk);
            eoc_n = 1'b0;
            repeat (3) @(posedge clk);
            eoc_n = 1'b1;
          end
        join_none
      end
    end
  endtask

  always @(negedge cs_n) begin
    gap_c = cyc - rise_c;
    bits = 0; bidx = 0;
    rd_frame = pending;
    if (rd_frame) begin
      wait_c = cyc - cmd_end_c;
      miso = get_bit(0);
    end
  end

  always @(posedge cs_n) begin
    rise_c = cyc;
    if (rd_frame) begin
      rd_bytes = bits / 8; pending = 0; rd_frame = 0;
    end else if (conv_frame) begin
      cmd_end_c = cyc; conv_frame = 0;
    end
  end

  always @(posedge sclk) if (!cs_n) begin
    sh_in = {sh_in[6:0], mosi};
    bits++;
    if (!rd_frame && bits % 8 == 0) decode(sh_in);
  end

  always @(negedge sclk) if (!cs_n && rd_frame) begin
    bidx++;
    miso = get_bit(bidx);
  end
endmodule

module adc_scan_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 2;
  localparam int CONV_CYC   = 40;
  localparam int TMO        = 3000;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       start_s [2], single_s [2], temp_s [2], ready_s [2], mute_s [2];
  logic [7:0] mask_s [2];
  logic       busy_w [2], err_w [2], valid_w [2], temp_w [2], last_w [2];
  logic       cs_w [2], sclk_w [2], mosi_w [2], miso_w [2], eoc_w [2];
  logic [15:0] data_w [2];
  logic [2:0]  ch_w [2];
  logic [7:0]  lcmd_w [2];
  logic [23:0] f3_w [2];
  int          ncmd_w [2], rdb_w [2], gap_w [2], wait_w [2];

  int checks = 0, errors = 0, cyc = 0;
  logic [20:0] exp_q [2][$];

  always @(posedge clk) cyc++;

  adc_scan_seq #(.NUM_CH(8), .RES_BITS(12), .EOC_IRQ(1'b1), .CLK_DIV(CLK_DIV),
                 .CONV_CYC(CONV_CYC), .TIMEOUT_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s[0]), .single_i(single_s[0]),
    .temp_i(temp_s[0]), .ch_mask_i(mask_s[0]), .busy_o(busy_w[0]), .err_o(err_w[0]),
    .smp_valid_o(valid_w[0]), .smp_ready_i(ready_s[0]), .smp_data_o(data_w[0]),
    .smp_ch_o(ch_w[0]), .smp_temp_o(temp_w[0]), .smp_last_o(last_w[0]),
    .cs_no(cs_w[0]), .sclk_o(sclk_w[0]), .mosi_o(mosi_w[0]), .miso_i(miso_w[0]),
    .eoc_ni(eoc_w[0]));

  adc_scan_seq #(.NUM_CH(8), .RES_BITS(10), .EOC_IRQ(1'b0), .CLK_DIV(CLK_DIV),
                 .CONV_CYC(CONV_CYC), .TIMEOUT_CYC(TMO)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s[1]), .single_i(single_s[1]),
    .temp_i(temp_s[1]), .ch_mask_i(mask_s[1]), .busy_o(busy_w[1]), .err_o(err_w[1]),
    .smp_valid_o(valid_w[1]), .smp_ready_i(ready_s[1]), .smp_data_o(data_w[1]),
    .smp_ch_o(ch_w[1]), .smp_temp_o(temp_w[1]), .smp_last_o(last_w[1]),
    .cs_no(cs_w[1]), .sclk_o(sclk_w[1]), .mosi_o(mosi_w[1]), .miso_i(miso_w[1]),
    .eoc_ni(eoc_w[1]));

  for (genvar g = 0; g < 2; g++) begin : g_side
    adc_model #(.EOC_DLY(30)) mdl (
      .clk(clk), .cs_n(cs_w[g]), .sclk(sclk_w[g]), .mosi(mosi_w[g]), .mute(mute_s[g]),
      .miso(miso_w[g]), .eoc_n(eoc_w[g]), .last_cmd(lcmd_w[g]), .n_cmds(ncmd_w[g]),
      .first3(f3_w[g]), .rd_bytes(rdb_w[g]), .gap_c(gap_w[g]), .wait_c(wait_w[g]));

    logic [7:0]  lfsr = 8'h5A + 8'(g);
    logic        stall = 0;
    logic [20:0] held;

    // scoreboard monitor: pops one expected item per handshake
    always @(negedge clk) begin
      logic [20:0] got, exp;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      got = {temp_w[g], last_w[g], ch_w[g], data_w[g]};
      if (stall) begin
        checks++;
        if (!valid_w[g] || got != held) begin
          errors++;
          $display("FAIL R11: side %0d stalled sample got %h exp %h", g, got, held);
        end
      end
      ready_s[g] = lfsr[0] | lfsr[1];
      stall = valid_w[g] && !ready_s[g];
      held  = got;
      if (valid_w[g] && ready_s[g]) begin
        checks++;
        if (exp_q[g].size() == 0) begin
          errors++;
          $display("FAIL R6: side %0d unexpected sample got %h exp none", g, got);
        end else begin
          exp = exp_q[g].pop_front();
          if (got != exp) begin
            errors++;
            $display("FAIL R6 R10: side %0d sample got %h exp %h", g, got, exp);
          end
        end
      end
    end
  end

  // R2: sclk high phase length
  int sclk_run = 0, sclk_bad = 0, sclk_hi = 0;
  always @(negedge clk) begin
    if (sclk_w[0]) sclk_run++;
    else if (sclk_run > 0) begin
      sclk_hi++;
      if (sclk_run != CLK_DIV) sclk_bad++;
      sclk_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] raw_val(input int k);
    return 16'h0A00 + 16'(k) * 16'h0013;
  endfunction

  function automatic logic [20:0] item(input int u, input bit t, input bit l,
                                       input int ch, input logic [15:0] raw);
    logic [15:0] d = (u == 1) ? (raw >> 2) : raw;
    return {t, l, 3'(ch), d};
  endfunction

  task automatic wait_idle(input int u);
    while (busy_w[u] && cyc < 150000) @(negedge clk);
  endtask

  task automatic run(input int u, input logic [7:0] mask, input bit t,
                     input bit single, input bit hold);
    int hi = 0, nconv, nbytes, nc0;
    logic [7:0] cmd;
    for (int i = 0; i < 8; i++) if (mask[i]) hi = i;
    if (single) begin
      cmd    = t ? 8'h87 : (8'h86 | 8'(hi << 3));
      nconv  = 1;
      nbytes = t ? 4 : 2;
      exp_q[u].push_back(t ? item(u, 1, 1, 0, 16'h0C35) : item(u, 0, 1, hi, raw_val(hi)));
    end else begin
      cmd    = 8'h80 | 8'(hi << 3) | 8'(t);
      nconv  = hi + 1 + int'(t);
      nbytes = 2 * nconv;
      if (t) exp_q[u].push_back(item(u, 1, hi == 0 ? 1'b0 : 1'b0, 0, 16'h0C35));
      for (int k = 0; k <= hi; k++) exp_q[u].push_back(item(u, 0, k == hi, k, raw_val(k)));
    end
    nc0 = ncmd_w[u];
    @(negedge clk);
    start_s[u] = 1; mask_s[u] = mask; temp_s[u] = t; single_s[u] = single;
    @(negedge clk);
    start_s[u] = hold;
    // R8: accepted start clears the sticky flag
    chk(err_w[u] == 1'b0, "R8 clear", int'(err_w[u]), 0);
    wait_idle(u);
    start_s[u] = 0;
    chk(lcmd_w[u] == cmd, single ? "R4 cmd" : "R3 cmd", int'(lcmd_w[u]), int'(cmd));
    chk(ncmd_w[u] == nc0 + 1, "R12 one command", ncmd_w[u] - nc0, 1);
    chk(exp_q[u].size() == 0, "R6 all samples", exp_q[u].size(), 0);
    chk(rdb_w[u] == nbytes, "R7 readback bytes", rdb_w[u], nbytes);
    chk(gap_w[u] >= 2 * CLK_DIV, "R5 cs gap", gap_w[u], 2 * CLK_DIV);
    if (u == 1) chk(wait_w[u] >= CONV_CYC * nconv, "R9 delay", wait_w[u], CONV_CYC * nconv);
    exp_q[u].delete();
  endtask

  initial begin
    for (int u = 0; u < 2; u++) begin
      start_s[u] = 0; single_s[u] = 0; temp_s[u] = 0; mask_s[u] = 0; mute_s[u] = 0;
      ready_s[u] = 0;
    end
    repeat (3) @(negedge clk);
    // reset state
    chk(busy_w[0] == 1'b1, "R1 busy in reset", int'(busy_w[0]), 1);
    chk(cs_w[0] == 1'b1 && sclk_w[0] == 1'b0, "R2 idle pins", int'({cs_w[0], sclk_w[0]}), 2);
    chk(valid_w[0] == 1'b0 && valid_w[1] == 1'b0, "R6 no sample in reset", int'(valid_w[0]), 0);
    chk(err_w[0] == 1'b0, "R8 err in reset", int'(err_w[0]), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy_w[0] == 1'b1 && busy_w[1] == 1'b1, "R1 busy during boot", int'(busy_w[0]), 1);
    wait_idle(0); wait_idle(1);
    chk(f3_w[0] == 24'h102068 && ncmd_w[0] == 3, "R1 boot bytes", int'(f3_w[0]), 24'h102068);
    chk(f3_w[1] == 24'h102068 && ncmd_w[1] == 3, "R1 boot bytes b", int'(f3_w[1]), 24'h102068);

    run(0, 8'b0000_0101, 0, 0, 0);
    run(0, 8'h80, 1, 0, 0);
    run(0, 8'h00, 0, 0, 0);   // empty mask -> channel 0
    run(0, 8'h08, 0, 1, 0);
    run(0, 8'h3C, 1, 1, 0);   // temperature single read, mask ignored

    // R8: timeout, no edge on the end-of-conversion line
    mute_s[0] = 1;
    @(negedge clk);
    start_s[0] = 1; mask_s[0] = 8'h03; temp_s[0] = 0; single_s[0] = 0;
    @(negedge clk);
    start_s[0] = 0;
    wait_idle(0);
    mute_s[0] = 0;
    chk(err_w[0] == 1'b1, "R8 timeout flag", int'(err_w[0]), 1);
    repeat (20) @(negedge clk);
    chk(err_w[0] == 1'b1 && valid_w[0] == 1'b0, "R8 sticky no sample", int'(err_w[0]), 1);

    // R12: start held high across the final handshake
    run(0, 8'h12, 1, 0, 1);

    run(1, 8'h0F, 1, 0, 0);   // R10 shifted data, R9 delay
    run(1, 8'h20, 0, 1, 0);
    run(1, 8'h01, 0, 0, 1);

    chk(sclk_bad == 0 && sclk_hi > 0, "R2 sclk high phase", sclk_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 160000) @(negedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule